// File: doc/BRIEF.md
# Receive Buffer Descriptor Filler

This block sits behind a network receiver. It takes each received frame as a byte stream and writes it into a ring of receive descriptors held in system memory. A descriptor is two 32-bit words: a status/length word and a buffer pointer. The block fetches the current descriptor and streams payload bytes into its buffer. When the buffer reaches the programmed maximum buffer size, or the frame ends, it writes the used length and status back and moves to the next descriptor. The 4-byte CRC-32 of the frame is appended after the payload, so it may fall partly in one buffer and partly in the next.

Oversized frames are cut short and flagged, and frames longer than a programmable limit are flagged. The final descriptor of a frame raises a frame event and every earlier one raises a buffer event. The block keeps a receive-active state. Software arms it with a demand pulse, and the block re-arms it after each frame from the empty bit of the next descriptor. The input stream is back-pressured whenever receive is inactive.

The memory port is a simple word port. Outputs are registered. A read returns data in `mem_rdata` one cycle after the request cycle.

Top module: `rx_desc_filler`

## Requirements
- R1: After reset, rx_active, s_ready, ev_rxb, ev_rxf and mem_req are all 0.
- R2: A descriptor at address D holds {flags[15:0], length[15:0]} in the word at D and the buffer pointer in the word at D+4. Flag bit 15 set means empty, and the bit is cleared in every descriptor written back. Memory is big-endian: the byte at offset 0 of a word is bits 31:24, enabled by mem_be[3].
- R3: The stored frame is the payload followed by 4 CRC bytes, most significant byte first. The CRC is the IEEE CRC-32 over all received payload bytes: reflected polynomial 0xEDB88320, initial value all ones, final inversion. The CRC bytes may be split across two buffers.
- R4: Payload bytes beyond 2028 are accepted but not stored. The stored length is then 2032, and the final flags carry truncated (bit 0) and length error (bit 5).
- R5: Every buffer except the last of a frame receives exactly the maximum buffer size. That size is taken as the written value ANDed with 0x7F0.
- R6: The final descriptor of a frame gets the last flag (bit 11) plus its error flags and pulses ev_rxf for one cycle. Each earlier descriptor pulses ev_rxb, and never both at once.
- R7: Length error (bit 5) is set when the stored length exceeds the frame limit, which resets to 1518 (0x05EE).
- R8: A written-back descriptor with wrap (bit 13) set sends the pointer back to the ring base; otherwise the pointer advances by 8. Writing the ring base, with its low two bits forced to 0, also loads the pointer.
- R9: A demand pulse takes effect only while ctl_en is high and rx_active is low, and sets rx_active to the empty bit of the current descriptor. ctl_en low clears rx_active.
- R10: When a frame completes, rx_active becomes the empty bit of the next descriptor.
- R11: While rx_active is low and no frame is in progress, s_ready stays low and no byte is taken.
- R12: If a non-empty descriptor is met inside a frame, filling stops: rx_active drops, no ev_rxf is raised, and the remaining payload bytes of that frame are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable level |
| rx_demand | input | 1 | Pulse asking receive to be armed |
| ring_wr | input | 1 | Load ring base and descriptor pointer |
| ring_data | input | 32 | Ring base byte address |
| bufsz_wr | input | 1 | Load maximum buffer size |
| bufsz_data | input | 16 | Maximum buffer size (masked 0x7F0) |
| frmlim_wr | input | 1 | Load frame length limit |
| frmlim_data | input | 16 | Frame length limit |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Byte is the last of the frame |
| s_ready | output | 1 | Stream byte taken this cycle |
| rx_active | output | 1 | Receive armed |
| ev_rxb | output | 1 | Non-final buffer completed |
| ev_rxf | output | 1 | Frame completed |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |

## Verification
The assertions assume that software keeps the maximum buffer size nonzero and leaves it, the ring base and the frame limit unchanged while a frame is in progress. They also assume memory answers every read on the following cycle. The stimulus changes those settings only between frames, after the block has gone idle. Its memory model returns read data on the cycle after each request, and it never writes zero as the buffer size. Frames of 10 to 2040 bytes with different buffer sizes cover full buffers, a CRC split across buffers, the truncation boundary, the limit boundary, wrap and stopping inside a frame.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  localparam int F_EMPTY = 15;
  localparam int F_WRAP  = 13;
  localparam int F_LAST  = 11;
  localparam int F_LONG  = 5;
  localparam int F_TRUNC = 0;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_DATA, S_WB, S_EN0, S_EN1, S_EN2, S_DRAIN
  } fill_state_t;

  function automatic logic [31:0] crc32_byte(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'h0, b};
    for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction
endpackage

// File: rtl/rxf_crc32.sv
`timescale 1ns/1ps
module rxf_crc32 (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);
  logic [31:0] acc;
  always_ff @(posedge clk) begin
    if (rst || clr) acc <= 32'hFFFF_FFFF;
    else if (en)    acc <= rxf_pkg::crc32_byte(acc, din);
  end
  assign crc_out = ~acc;
endmodule

// File: rtl/rxf_len.sv
`timescale 1ns/1ps
module rxf_len #(
  parameter int MAX_FRAME = 2032,
  parameter int CRC_BYTES = 4,
  parameter int CW        = $clog2(MAX_FRAME + 1) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [15:0]   lim,
  output logic          keep,
  output logic          trunc,
  output logic          long_err,
  output logic [CW-1:0] stored
);
  localparam int PAY_MAX = MAX_FRAME - CRC_BYTES;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt <= CW'(PAY_MAX)) cnt <= cnt + 1'b1;
  end

  assign keep     = cnt < CW'(PAY_MAX);
  assign trunc    = cnt > CW'(PAY_MAX);
  assign stored   = (trunc ? CW'(PAY_MAX) : cnt) + CW'(CRC_BYTES);
  assign long_err = trunc || (16'(stored) > lim);
endmodule

// File: rtl/rx_desc_filler.sv
`timescale 1ns/1ps
module rx_desc_filler #(
  parameter int          AW        = 32,
  parameter int          MAX_FRAME = 2032,
  parameter logic [15:0] LIM_RESET = 16'h05EE,
  parameter logic [15:0] BUF_MASK  = 16'h07F0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_en,
  input  logic          rx_demand,
  input  logic          ring_wr,
  input  logic [AW-1:0] ring_data,
  input  logic          bufsz_wr,
  input  logic [15:0]   bufsz_data,
  input  logic          frmlim_wr,
  input  logic [15:0]   frmlim_data,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          rx_active,
  output logic          ev_rxb,
  output logic          ev_rxf,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  import rxf_pkg::*;
  localparam int CRC_BYTES = 4;
  localparam int CW = $clog2(MAX_FRAME + 1) + 1;
  localparam logic [AW-1:0] ALIGN = {{(AW-2){1'b1}}, 2'b00};

  fill_state_t   state;
  logic          act_q, crc_phase, is_last;
  logic [1:0]    crc_idx;
  logic [AW-1:0] ring_base, desc_ptr, d_buf, byte_addr;
  logic [15:0]   bufsz, frmlim, d_flags, buf_cnt, flags_new;
  logic [31:0]   crc_val;
  logic [7:0]    crc_sel;
  logic          accept, frame_start, keep, trunc, long_err, buf_full;
  logic [CW-1:0] stored;

  assign s_ready     = (state == S_DATA && !crc_phase) || (state == S_DRAIN);
  assign accept      = s_valid && s_ready;
  assign frame_start = (state == S_IDLE) && act_q && s_valid;
  assign rx_active   = act_q;
  assign byte_addr   = d_buf + AW'(buf_cnt);
  assign buf_full    = (buf_cnt + 16'd1) == bufsz;
  assign crc_sel     = 8'(crc_val >> {~crc_idx, 3'b000});

  always_comb begin
    flags_new = d_flags;
    flags_new[F_EMPTY] = 1'b0;
    if (is_last) begin
      flags_new[F_LAST]  = 1'b1;
      flags_new[F_TRUNC] = trunc;
      flags_new[F_LONG]  = long_err;
    end
  end

  rxf_crc32 u_crc (
    .clk(clk), .rst(rst), .clr(frame_start),
    .en(accept && state == S_DATA), .din(s_data), .crc_out(crc_val)
  );

  rxf_len #(.MAX_FRAME(MAX_FRAME), .CRC_BYTES(CRC_BYTES), .CW(CW)) u_len (
    .clk(clk), .rst(rst), .clr(frame_start), .inc(accept && state == S_DATA),
    .lim(frmlim), .keep(keep), .trunc(trunc), .long_err(long_err), .stored(stored)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;   act_q <= 1'b0;      crc_phase <= 1'b0;  is_last <= 1'b0;
      crc_idx <= '0;     ring_base <= '0;    desc_ptr <= '0;     d_buf <= '0;
      bufsz <= BUF_MASK; frmlim <= LIM_RESET; d_flags <= '0;     buf_cnt <= '0;
      ev_rxb <= 1'b0;    ev_rxf <= 1'b0;     mem_req <= 1'b0;    mem_we <= 1'b0;
      mem_addr <= '0;    mem_be <= '0;       mem_wdata <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      ev_rxb  <= 1'b0;
      ev_rxf  <= 1'b0;
      if (bufsz_wr)  bufsz  <= bufsz_data & BUF_MASK;
      if (frmlim_wr) frmlim <= frmlim_data;
      case (state)
        S_IDLE: begin
          if (ctl_en && rx_demand && !act_q) state <= S_EN0;
          else if (frame_start) begin
            crc_phase <= 1'b0;
            state     <= S_RD0;
          end
        end
        S_RD0: begin
          mem_req <= 1'b1; mem_addr <= desc_ptr; mem_be <= 4'hF;
          state   <= S_RD1;
        end
        S_RD1: begin
          mem_req <= 1'b1; mem_addr <= desc_ptr + AW'(4); mem_be <= 4'hF;
          state   <= S_RD2;
        end
        S_RD2: begin
          d_flags <= mem_rdata[31:16];
          state   <= S_RD3;
        end
        S_RD3: begin
          d_buf   <= mem_rdata[AW-1:0];
          buf_cnt <= '0;
          if (d_flags[F_EMPTY]) state <= S_DATA;
          else begin
            act_q <= 1'b0;
            state <= crc_phase ? S_IDLE : S_DRAIN;
          end
        end
        S_DATA: begin
          if (!crc_phase) begin
            if (accept) begin
              if (keep) begin
                mem_req   <= 1'b1; mem_we <= 1'b1;
                mem_addr  <= byte_addr & ALIGN;
                mem_be    <= 4'b1000 >> byte_addr[1:0];
                mem_wdata <= {4{s_data}};
                buf_cnt   <= buf_cnt + 16'd1;
                if (buf_full) begin
                  is_last <= 1'b0;
                  state   <= S_WB;
                end
              end
              if (s_last) begin
                crc_phase <= 1'b1;
                crc_idx   <= '0;
              end
            end
          end else begin
            mem_req   <= 1'b1; mem_we <= 1'b1;
            mem_addr  <= byte_addr & ALIGN;
            mem_be    <= 4'b1000 >> byte_addr[1:0];
            mem_wdata <= {4{crc_sel}};
            buf_cnt   <= buf_cnt + 16'd1;
            crc_idx   <= crc_idx + 2'd1;
            if (crc_idx == 2'd3) begin
              is_last <= 1'b1;
              state   <= S_WB;
            end else if (buf_full) begin
              is_last <= 1'b0;
              state   <= S_WB;
            end
          end
        end
        S_WB: begin
          mem_req   <= 1'b1; mem_we <= 1'b1; mem_be <= 4'hF;
          mem_addr  <= desc_ptr;
          mem_wdata <= {flags_new, buf_cnt};
          ev_rxf    <= is_last;
          ev_rxb    <= !is_last;
          desc_ptr  <= d_flags[F_WRAP] ? ring_base : desc_ptr + AW'(8);
          state     <= is_last ? S_EN0 : S_RD0;
        end
        S_EN0: begin
          mem_req <= 1'b1; mem_addr <= desc_ptr; mem_be <= 4'hF;
          state   <= S_EN1;
        end
        S_EN1: state <= S_EN2;
        S_EN2: begin
          act_q <= mem_rdata[31] && ctl_en;
          state <= S_IDLE;
        end
        S_DRAIN: if (accept && s_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (ring_wr) begin
        ring_base <= ring_data & ALIGN;
        desc_ptr  <= ring_data & ALIGN;
      end
      if (!ctl_en) act_q <= 1'b0;
    end
  end

  // R9: enable level low leaves receive inactive
  a_r9_ctl_off: assert property (@(posedge clk) disable iff (rst) !ctl_en |=> !rx_active);
  // R6: a descriptor raises one kind of event only
  a_r6_one_event: assert property (@(posedge clk) disable iff (rst) !(ev_rxb && ev_rxf));
  // R5: non-final buffers are written back full
  a_r5_full_buffer: assert property (@(posedge clk) disable iff (rst) ev_rxb |-> mem_wdata[15:0] == bufsz);
  // R4: stored length never exceeds the frame cap
  a_r4_len_cap: assert property (@(posedge clk) disable iff (rst) ev_rxf |-> mem_wdata[15:0] <= 16'(MAX_FRAME));
  // R2: written-back descriptor is a word write with empty cleared
  a_r2_empty_clear: assert property (@(posedge clk) disable iff (rst)
    (ev_rxb || ev_rxf) |-> (mem_req && mem_we && mem_be == 4'hF && !mem_wdata[31]));
  // R12: discarding a frame tail only happens with receive inactive
  a_r12_drain_inactive: assert property (@(posedge clk) disable iff (rst) (state == S_DRAIN) |-> !rx_active);
endmodule

// File: tb/test_rx_desc_filler.sv
`timescale 1ns/1ps
module test_rx_desc_filler;
  logic clk = 0, rst = 1;
  logic ctl_en = 0, rx_demand = 0, ring_wr = 0, bufsz_wr = 0, frmlim_wr = 0;
  logic [31:0] ring_data = 0;
  logic [15:0] bufsz_data = 0, frmlim_data = 0;
  logic s_valid = 0, s_last = 0;
  logic [7:0] s_data = 0;
  logic s_ready, rx_active, ev_rxb, ev_rxf, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic [3:0] mem_be;

  rx_desc_filler i_rx_desc_filler (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .rx_demand(rx_demand),
    .ring_wr(ring_wr), .ring_data(ring_data), .bufsz_wr(bufsz_wr), .bufsz_data(bufsz_data),
    .frmlim_wr(frmlim_wr), .frmlim_data(frmlim_data), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_ready(s_ready), .rx_active(rx_active), .ev_rxb(ev_rxb), .ev_rxf(ev_rxf),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #5 clk = ~clk;

  logic [7:0] act_mem [int unsigned];
  logic [7:0] exp_mem [int unsigned];
  int nvec = 0, nfail = 0, act_rxb = 0, act_rxf = 0, exp_rxb = 0, exp_rxf = 0;
  int unsigned m_base = 0, m_ptr = 0, m_bufsz = 16'h07F0, m_lim = 16'h05EE;
  bit m_active = 0, m_ctl = 0;

  function automatic logic [7:0] act_b(input int unsigned a);
    return act_mem.exists(a) ? act_mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] exp_b(input int unsigned a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
  endfunction
  function automatic logic [31:0] exp_w(input int unsigned a);
    return {exp_b(a), exp_b(a + 1), exp_b(a + 2), exp_b(a + 3)};
  endfunction

  // memory model: byte-addressed, big-endian lanes, read data one cycle later
  always @(posedge clk) begin
    if (!rst && mem_req) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[3-k]) act_mem[{mem_addr[31:2], 2'b00} + k] = mem_wdata[31-8*k -: 8];
      end else begin
        mem_rdata <= {act_b(mem_addr), act_b(mem_addr + 1), act_b(mem_addr + 2), act_b(mem_addr + 3)};
      end
    end
    if (!rst && ev_rxb) act_rxb++;
    if (!rst && ev_rxf) act_rxf++;
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R11 watchdog: actual=hung expected=done");
    report();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_w(input int unsigned a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) begin
      act_mem[a + k] = w[31-8*k -: 8];
      exp_mem[a + k] = w[31-8*k -: 8];
    end
  endtask

  task automatic put_desc(input int idx, input logic [15:0] flags);
    put_w(32'h1000 + 8 * idx, {flags, 16'h0000});
    put_w(32'h1004 + 8 * idx, 32'h2000 + 32'h800 * idx);
  endtask

  task automatic set_ring(input logic [31:0] v);
    @(negedge clk); ring_wr = 1; ring_data = v;
    @(negedge clk); ring_wr = 0;
    m_base = v & 32'hFFFF_FFFC; m_ptr = m_base;
  endtask

  task automatic set_bufsz(input logic [15:0] v);
    @(negedge clk); bufsz_wr = 1; bufsz_data = v;
    @(negedge clk); bufsz_wr = 0;
    m_bufsz = v & 16'h07F0;
  endtask

  task automatic set_lim(input logic [15:0] v);
    @(negedge clk); frmlim_wr = 1; frmlim_data = v;
    @(negedge clk); frmlim_wr = 0;
    m_lim = v;
  endtask

  task automatic set_ctl(input bit v);
    @(negedge clk); ctl_en = v; m_ctl = v;
    if (!v) m_active = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic demand();
    @(negedge clk); rx_demand = 1;
    @(negedge clk); rx_demand = 0;
    if (m_ctl && !m_active) m_active = exp_b(m_ptr)[7];
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] q[$]);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    foreach (q[i]) begin
      c = c ^ {24'h0, q[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic model_frame(input logic [7:0] pay[$]);
    logic [7:0] st[$];
    logic [31:0] c, bptr;
    logic [15:0] flags, err;
    int n, keep, size, idx, take;
    n = pay.size();
    keep = (n > 2028) ? 2028 : n;
    c = ref_crc(pay);
    for (int i = 0; i < keep; i++) st.push_back(pay[i]);
    for (int k = 0; k < 4; k++) st.push_back(c[31-8*k -: 8]);
    size = st.size();
    err = 0;
    if (n > 2028) err = err | 16'h0021;
    if (size > m_lim) err = err | 16'h0020;
    idx = 0;
    while (1) begin
      flags = exp_w(m_ptr)[31:16];
      bptr  = exp_w(m_ptr + 4);
      if (!flags[15]) begin m_active = 0; break; end
      take = (size - idx < m_bufsz) ? size - idx : m_bufsz;
      for (int j = 0; j < take; j++) exp_mem[bptr + j] = st[idx + j];
      idx += take;
      flags[15] = 0;
      if (idx == size) begin flags = flags | 16'h0800 | err; exp_rxf++; end
      else exp_rxb++;
      for (int k = 0; k < 4; k++) exp_mem[m_ptr + k] = {flags, 16'(take)}[31-8*k -: 8];
      m_ptr = flags[13] ? m_base : m_ptr + 8;
      if (idx == size) begin m_active = exp_b(m_ptr)[7] && m_ctl; break; end
    end
  endtask

  task automatic send_frame(input logic [7:0] q[$]);
    foreach (q[i]) begin
      int tmo;
      bit got;
      tmo = 0; got = 0;
      while (!got) begin
        @(negedge clk);
        s_valid = 1; s_data = q[i]; s_last = (i == q.size() - 1);
        #1;
        if (s_ready) begin got = 1; @(posedge clk); end
        tmo++;
        if (tmo > 300) begin
          chk(0, "R12", "stream stalled", 0, 1);
          s_valid = 0; s_last = 0;
          return;
        end
      end
    end
    @(negedge clk); s_valid = 0; s_last = 0;
  endtask

  task automatic compare(input string req);
    int bad;
    int unsigned where;
    bad = 0; where = 0;
    foreach (exp_mem[a]) if (!act_mem.exists(a) || act_mem[a] != exp_mem[a]) begin
      if (bad == 0) where = a;
      bad++;
    end
    foreach (act_mem[a]) if (!exp_mem.exists(a)) begin
      if (bad == 0) where = a;
      bad++;
    end
    chk(bad == 0, req, $sformatf("memory image at %0h", where), act_b(where), exp_b(where));
    chk(act_rxb == exp_rxb, req, "buffer events", act_rxb, exp_rxb);
    chk(act_rxf == exp_rxf, req, "frame events", act_rxf, exp_rxf);
    chk(rx_active == m_active, req, "rx_active", rx_active, m_active);
  endtask

  task automatic frame(input int n, input int seed, input string req);
    logic [7:0] q[$];
    for (int i = 0; i < n; i++) q.push_back(8'((seed * 7 + i * 13 + (i >> 8)) & 8'hFF));
    send_frame(q);
    model_frame(q);
    repeat (40) @(negedge clk);
    compare(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(rx_active == 0, "R1", "rx_active after reset", rx_active, 0);
    chk(s_ready == 0, "R1", "s_ready after reset", s_ready, 0);
    chk(!ev_rxb && !ev_rxf, "R1", "events after reset", {ev_rxb, ev_rxf}, 0);
    chk(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);

    for (int d = 0; d < 4; d++) put_desc(d, (d == 3) ? 16'hA000 : 16'h8000);
    set_ring(32'h1000);
    set_bufsz(16'd32);
    demand();
    chk(rx_active == 0, "R9", "demand with controller off", rx_active, 0);
    set_ctl(1);
    demand();
    chk(rx_active == 1, "R9", "demand arms from empty descriptor", rx_active, 1);

    frame(10, 1, "R3");   // single buffer with CRC, R6 final flags
    frame(60, 2, "R5");   // two full buffers, R6 buffer and frame events
    frame(30, 3, "R8");   // CRC split, wrap to used descriptor, R12 stop, R10 inactive

    // R11: nothing taken while inactive
    @(negedge clk); s_valid = 1; s_data = 8'h5A; s_last = 1;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (s_ready) seen++; end
      chk(seen == 0, "R11", "s_ready while inactive", seen, 0);
    end
    s_valid = 0; s_last = 0;
    repeat (5) @(negedge clk);
    compare("R11");

    for (int d = 0; d < 4; d++) put_desc(d, (d == 3) ? 16'hA000 : 16'h8000);
    set_ring(32'h1003);
    set_bufsz(16'hFFFF);
    demand();
    chk(rx_active == 1, "R8", "ring base reload arms at base", rx_active, 1);
    frame(1514, 4, "R7");  // stored 1518 at reset limit: no length error
    frame(1515, 5, "R7");  // stored 1519: length error
    frame(2040, 6, "R4");  // truncated to 2032
    set_lim(16'd20);
    frame(20, 7, "R10");   // length error vs new limit, wrap to used descriptor

    put_desc(0, 16'h8000); put_desc(1, 16'h8000); put_desc(2, 16'h0000); put_desc(3, 16'h0000);
    set_ring(32'h1000);
    set_bufsz(16'd16);
    set_lim(16'hFFFF);
    demand();
    frame(50, 8, "R12");   // runs out mid payload, tail discarded

    put_desc(2, 16'h8000);
    demand();
    chk(rx_active == 1, "R9", "re-demand on refilled descriptor", rx_active, 1);
    set_ctl(0);
    chk(rx_active == 0, "R9", "controller off clears receive", rx_active, 0);
    demand();
    chk(rx_active == 0, "R9", "demand ignored while controller off", rx_active, 0);

    report();
  end
endmodule